// File: doc/BRIEF.md
# Trigger and Dead-Time Scaler Bank

This block keeps ten running counters for a trigger system and makes them readable through a narrow 16-bit command port. Eight counters, one per intermediate coincidence signal, count that signal's rising edges. A ninth counter counts rising edges of the logic trigger. A tenth counts the clock cycles during which the LAM request is held high, which gives a direct measure of accumulated dead time. Every counter stops at its all-ones value instead of wrapping.

Commands arrive as a one-cycle strobe that carries a function code and a sub-address. The read function loads the selected value into a data register on the next clock. The 24-bit counters are read as two 16-bit halves: the low half first, then a high half whose unused upper bits read zero. The clear function resets one counter, or all of them at the top sub-address. The synchronous active-low reset clears the whole bank. All inputs are assumed to be synchronous to `clk`.

Top module: `trig_scaler_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every counter and `rd_data_o` become 0 on that edge.
- R2: Each intermediate counter (sub-addresses 0 to 7, in the order F1X, F2X, F3X, F4X, F1Y, F2Y, F3Y, F4Y, bit i of `trig_i` feeding sub-address i) adds one for each rising edge of its input. A level held high for many cycles counts once. A level that is already high when reset is released does not count.
- R3: Counters saturate. An EVT_W-bit counter stops at 2^EVT_W-1 and a LONG_W-bit counter stops at 2^LONG_W-1, with the defaults 0xFFFF and 0xFFFFFF.
- R4: The logic-trigger counter is LONG_W bits (24 by default) and adds one per rising edge of `logic_trig_i`.
- R5: The dead-time counter is LONG_W bits and adds one for every clock edge at which `lam_req_i` is high. It holds while `lam_req_i` is low.
- R6: A read command (`cmd_valid_i` high with `cmd_func_i` = 2) loads `rd_data_o` on that clock edge with the value the addressed counter had before the edge. For sub-addresses 0 to 7 the event counter is returned zero-extended. `rd_data_o` holds its value in every cycle with no read command.
- R7: A read at sub-address 12 returns bits 15:0 of the dead-time counter, and 13 returns its bits above 15 in the low bits of `rd_data_o`. A read at 14 returns bits 15:0 of the logic-trigger counter, and 15 returns its bits above 15 in the same way. In a high-half read, bits 15 to LONG_W-16 (15:8 by default) are 0.
- R8: A clear command (`cmd_func_i` = 11) at sub-address 0 to 7, 12 or 14 sets only that counter (event counter n, dead-time, logic-trigger respectively) to 0 and leaves the others unchanged. A clear takes priority over an increment in the same cycle.
- R9: A clear command at sub-address 15 sets all ten counters to 0.
- R10: Reads at sub-addresses 8 to 11 return 0. Clear commands at 8 to 11 or 13 and commands with any other function code change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low module reset |
| trig_i | input | N_TRIG (8) | Intermediate coincidence signals, bit i counted at sub-address i |
| logic_trig_i | input | 1 | Logic trigger signal |
| lam_req_i | input | 1 | LAM request level, counted per clock for dead time |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_func_i | input | 5 | Function code: 2 read, 11 clear |
| cmd_addr_i | input | 4 | Sub-address |
| rd_data_o | output | BUS_W (16) | Registered read data |

## Verification
The bench goes after a trigger level held high for several cycles: a level detector instead of an edge detector would count it more than once. It places a rising edge in the same cycle as that counter's clear. A design that gave the increment priority would read 1 there, and an edge detector that lost its history would count the still-high level again afterwards. It drives an event counter and the dead-time counter past full scale, which exposes wrap-around and a high half that is mis-sliced or carries stray upper bits. It also checks that clears at unused sub-addresses and foreign function codes leave the bank intact, which catches a sub-address decoder that is too wide.

// File: rtl/trig_scaler_pkg.sv
// Package: shared command codes and sub-address map for the scaler bank.
// Assumes a 5-bit function field and a 4-bit sub-address field.
package trig_scaler_pkg;
    localparam int FUNC_W = 5;
    localparam int ADDR_W = 4;

    localparam logic [FUNC_W-1:0] FN_READ  = 5'd2;
    localparam logic [FUNC_W-1:0] FN_CLEAR = 5'd11;

    localparam logic [ADDR_W-1:0] SA_LAM_LO = 4'd12;
    localparam logic [ADDR_W-1:0] SA_LAM_HI = 4'd13;
    localparam logic [ADDR_W-1:0] SA_LT_LO  = 4'd14;
    localparam logic [ADDR_W-1:0] SA_LT_HI  = 4'd15;
    localparam logic [ADDR_W-1:0] SA_ALL    = 4'd15;
endpackage

// File: rtl/sat_counter.sv
// Saturating up-counter with synchronous clear.
// Stops at all-ones. Reset and clear both win over increment.
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    // Count up, hold at full scale, clear on reset or command.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o <= '0;
        end else if (inc_i && (cnt_o != CNT_MAX)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/rise_detect.sv
// Rising-edge detector for N synchronous signals.
// The history resets to all ones, so a level already high at reset
// release is not taken as an edge.
module rise_detect #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] hist_q;

    // Remember last cycle's levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else begin
            hist_q <= sig_i;
        end
    end

    // Edge is high now, low last cycle.
    always_comb begin
        rise_o = sig_i & ~hist_q;
    end
endmodule

// File: rtl/scaler_cmd_decode.sv
// Command decoder: turns a function/sub-address strobe into per-counter
// clear lines and a read enable. Clear bits [N_TRIG-1:0] are the event
// counters, bit N_TRIG the logic-trigger counter, bit N_TRIG+1 dead time.
module scaler_cmd_decode
    import trig_scaler_pkg::*;
#(
    parameter int N_TRIG = 8
) (
    input  logic              cmd_valid_i,
    input  logic [FUNC_W-1:0] cmd_func_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    output logic [N_TRIG+1:0] clr_o,
    output logic              rd_en_o
);
    localparam int IDX_LT  = N_TRIG;
    localparam int IDX_LAM = N_TRIG + 1;

    logic is_clear;

    // Qualify the function code.
    always_comb begin
        is_clear = cmd_valid_i && (cmd_func_i == FN_CLEAR);
        rd_en_o  = cmd_valid_i && (cmd_func_i == FN_READ);
    end

    // Map the sub-address to clear lines.
    always_comb begin
        clr_o = '0;
        if (is_clear) begin
            if (cmd_addr_i == SA_ALL) begin
                clr_o = '1;
            end else if (cmd_addr_i == SA_LAM_LO) begin
                clr_o[IDX_LAM] = 1'b1;
            end else if (cmd_addr_i == SA_LT_LO) begin
                clr_o[IDX_LT] = 1'b1;
            end else begin
                for (int i = 0; i < N_TRIG; i++) begin
                    if (cmd_addr_i == ADDR_W'(i)) begin
                        clr_o[i] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/scaler_read_mux.sv
// Read selector: picks the 16-bit word for a sub-address.
// Assumes EVT_W <= BUS_W and BUS_W < LONG_W < 2*BUS_W.
module scaler_read_mux
    import trig_scaler_pkg::*;
#(
    parameter int N_TRIG = 8,
    parameter int EVT_W  = 16,
    parameter int LONG_W = 24,
    parameter int BUS_W  = 16
) (
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [N_TRIG-1:0][EVT_W-1:0]  evt_cnt_i,
    input  logic [LONG_W-1:0]             lt_cnt_i,
    input  logic [LONG_W-1:0]             lam_cnt_i,
    output logic [BUS_W-1:0]              word_o
);
    localparam int WIDE_W = 2 * BUS_W;

    logic [WIDE_W-1:0] lt_wide;
    logic [WIDE_W-1:0] lam_wide;

    // Zero-extend the long counters to two full bus words.
    always_comb begin
        lt_wide                = '0;
        lt_wide[LONG_W-1:0]    = lt_cnt_i;
        lam_wide               = '0;
        lam_wide[LONG_W-1:0]   = lam_cnt_i;
    end

    // Select the addressed word, zero for unmapped addresses.
    always_comb begin
        word_o = '0;
        case (addr_i)
            SA_LAM_LO: word_o = lam_wide[BUS_W-1:0];
            SA_LAM_HI: word_o = lam_wide[WIDE_W-1:BUS_W];
            SA_LT_LO:  word_o = lt_wide[BUS_W-1:0];
            SA_LT_HI:  word_o = lt_wide[WIDE_W-1:BUS_W];
            default: begin
                for (int i = 0; i < N_TRIG; i++) begin
                    if (addr_i == ADDR_W'(i)) begin
                        word_o[EVT_W-1:0] = evt_cnt_i[i];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/trig_scaler_bank.sv
// Trigger and dead-time scaler bank: N_TRIG edge counters, one
// logic-trigger edge counter and one clock-gated dead-time counter,
// with a registered read port and per-counter or global clear.
// Assumes all inputs synchronous to clk and N_TRIG <= 12.
module trig_scaler_bank
    import trig_scaler_pkg::*;
#(
    parameter int N_TRIG = 8,
    parameter int EVT_W  = 16,
    parameter int LONG_W = 24,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-1:0] trig_i,
    input  logic              logic_trig_i,
    input  logic              lam_req_i,
    input  logic              cmd_valid_i,
    input  logic [FUNC_W-1:0] cmd_func_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    output logic [BUS_W-1:0]  rd_data_o
);
    localparam int N_EDGE  = N_TRIG + 1;
    localparam int IDX_LT  = N_TRIG;
    localparam int IDX_LAM = N_TRIG + 1;

    logic [N_EDGE-1:0]             edge_in;
    logic [N_EDGE-1:0]             edge_hit;
    logic [N_TRIG+1:0]             clr_vec;
    logic                          rd_en;
    logic [N_TRIG-1:0][EVT_W-1:0]  evt_cnt;
    logic [LONG_W-1:0]             lt_cnt;
    logic [LONG_W-1:0]             lam_cnt;
    logic [BUS_W-1:0]              rd_word;

    // Gather all edge-counted inputs into one vector.
    always_comb begin
        edge_in = {logic_trig_i, trig_i};
    end

    rise_detect #(.N(N_EDGE)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (edge_in),
        .rise_o (edge_hit)
    );

    scaler_cmd_decode #(.N_TRIG(N_TRIG)) u_dec (
        .cmd_valid_i (cmd_valid_i),
        .cmd_func_i  (cmd_func_i),
        .cmd_addr_i  (cmd_addr_i),
        .clr_o       (clr_vec),
        .rd_en_o     (rd_en)
    );

    for (genvar g = 0; g < N_TRIG; g++) begin : g_evt
        sat_counter #(.W(EVT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_vec[g]),
            .inc_i (edge_hit[g]),
            .cnt_o (evt_cnt[g])
        );
    end

    sat_counter #(.W(LONG_W)) u_lt_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_vec[IDX_LT]),
        .inc_i (edge_hit[IDX_LT]),
        .cnt_o (lt_cnt)
    );

    sat_counter #(.W(LONG_W)) u_lam_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_vec[IDX_LAM]),
        .inc_i (lam_req_i),
        .cnt_o (lam_cnt)
    );

    scaler_read_mux #(
        .N_TRIG (N_TRIG),
        .EVT_W  (EVT_W),
        .LONG_W (LONG_W),
        .BUS_W  (BUS_W)
    ) u_mux (
        .addr_i    (cmd_addr_i),
        .evt_cnt_i (evt_cnt),
        .lt_cnt_i  (lt_cnt),
        .lam_cnt_i (lam_cnt),
        .word_o    (rd_word)
    );

    // Capture the selected word on a read command, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en) begin
            rd_data_o <= rd_word;
        end
    end
endmodule

// File: rtl/trig_scaler_bank_chk.sv
// Checker for the scaler bank: watches the ports and the counter values
// and flags any departure from the reset, step, saturation, clear and
// read rules. Attached to every instance through bind.
module trig_scaler_bank_chk
    import trig_scaler_pkg::*;
#(
    parameter int N_TRIG = 8,
    parameter int EVT_W  = 16,
    parameter int LONG_W = 24,
    parameter int BUS_W  = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          lam_req_i,
    input logic                          cmd_valid_i,
    input logic [FUNC_W-1:0]             cmd_func_i,
    input logic [ADDR_W-1:0]             cmd_addr_i,
    input logic [BUS_W-1:0]              rd_data_o,
    input logic [N_TRIG-1:0][EVT_W-1:0]  evt_cnt,
    input logic [LONG_W-1:0]             lt_cnt,
    input logic [LONG_W-1:0]             lam_cnt
);
    localparam int HI_USED = LONG_W - BUS_W;

    logic is_rd, is_clr, clr_all, clr_lam;

    // Decode commands independently from the ports.
    always_comb begin
        is_rd   = cmd_valid_i && (cmd_func_i == FN_READ);
        is_clr  = cmd_valid_i && (cmd_func_i == FN_CLEAR);
        clr_all = is_clr && (cmd_addr_i == 4'd15);
        clr_lam = is_clr && ((cmd_addr_i == 4'd12) || (cmd_addr_i == 4'd15));
    end

    // R1: reset clears counters and read data.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (lam_cnt == '0 && lt_cnt == '0 && evt_cnt == '0 && rd_data_o == '0));

    // R3: the dead-time counter never wraps from full scale.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lam_cnt == {LONG_W{1'b1}} && !clr_lam) |=> (lam_cnt == {LONG_W{1'b1}}));

    // R5: one step per clock of LAM request.
    p_lam_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lam_req_i && !clr_lam && lam_cnt != {LONG_W{1'b1}})
        |=> (lam_cnt == $past(lam_cnt) + 1'b1));

    // R5: hold while LAM request is low.
    p_lam_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lam_req_i && !clr_lam) |=> $stable(lam_cnt));

    // R6: read data holds between read commands.
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> $stable(rd_data_o));

    // R7: unused upper bits of a high-half read are zero.
    p_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && (cmd_addr_i == 4'd13 || cmd_addr_i == 4'd15))
        |=> (rd_data_o[BUS_W-1:HI_USED] == '0));

    // R9: clear-all empties the bank.
    p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (lam_cnt == '0 && lt_cnt == '0 && evt_cnt == '0));
endmodule

bind trig_scaler_bank trig_scaler_bank_chk #(
    .N_TRIG (N_TRIG),
    .EVT_W  (EVT_W),
    .LONG_W (LONG_W),
    .BUS_W  (BUS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lam_req_i   (lam_req_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_func_i  (cmd_func_i),
    .cmd_addr_i  (cmd_addr_i),
    .rd_data_o   (rd_data_o),
    .evt_cnt     (evt_cnt),
    .lt_cnt      (lt_cnt),
    .lam_cnt     (lam_cnt)
);

// File: tb/trig_scaler_bank_bench.sv
// Bench: narrowed counters so saturation is reachable, seeded random
// trigger traffic plus directed corner cases, checked against a
// behavioural model written from the requirements.
module trig_scaler_bank_bench;
    localparam int N_TRIG = 8;
    localparam int EVT_W  = 8;
    localparam int LONG_W = 17;
    localparam int BUS_W  = 16;
    localparam int EMAX   = (1 << EVT_W) - 1;
    localparam int LMAX   = (1 << LONG_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_TRIG-1:0] trig = '0;
    logic              ltrig = 1'b0;
    logic              lam = 1'b0;
    logic              cv = 1'b0;
    logic [4:0]        cf = '0;
    logic [3:0]        ca = '0;
    logic [BUS_W-1:0]  rd;

    int n_chk = 0;
    int n_fail = 0;

    int         m_evt [N_TRIG];
    int         m_lt, m_lam;
    logic [N_TRIG-1:0] m_prev;
    logic       m_lprev;

    always #4 clk = ~clk;

    trig_scaler_bank #(
        .N_TRIG (N_TRIG), .EVT_W (EVT_W), .LONG_W (LONG_W), .BUS_W (BUS_W)
    ) u_trig_scaler_bank (
        .clk (clk), .rst_n (rst_n), .trig_i (trig), .logic_trig_i (ltrig),
        .lam_req_i (lam), .cmd_valid_i (cv), .cmd_func_i (cf),
        .cmd_addr_i (ca), .rd_data_o (rd)
    );

    // Reference model of the counters, from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_TRIG; i++) m_evt[i] = 0;
            m_lt = 0; m_lam = 0; m_prev = '1; m_lprev = 1'b1;
        end else begin
            for (int i = 0; i < N_TRIG; i++) begin
                if (cv && cf == 5'd11 && (ca == 4'd15 || ca == 4'(i))) m_evt[i] = 0;
                else if (trig[i] && !m_prev[i] && m_evt[i] < EMAX) m_evt[i]++;
            end
            if (cv && cf == 5'd11 && (ca == 4'd15 || ca == 4'd14)) m_lt = 0;
            else if (ltrig && !m_lprev && m_lt < LMAX) m_lt++;
            if (cv && cf == 5'd11 && (ca == 4'd15 || ca == 4'd12)) m_lam = 0;
            else if (lam && m_lam < LMAX) m_lam++;
            m_prev = trig; m_lprev = ltrig;
        end
    end

    function automatic logic [15:0] exp_read(input int a);
        if (a < N_TRIG) return 16'(m_evt[a]);
        case (a)
            12: return 16'(m_lam & 32'hFFFF);
            13: return 16'(m_lam >> 16);
            14: return 16'(m_lt & 32'hFFFF);
            15: return 16'(m_lt >> 16);
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [4:0] f, input logic [3:0] a);
        @(negedge clk);
        cv = 1'b1; cf = f; ca = a;
        @(negedge clk);
        cv = 1'b0;
    endtask

    task automatic rd_chk(input int a, input string tag);
        logic [15:0] e;
        @(negedge clk);
        cv = 1'b1; cf = 5'd2; ca = 4'(a);
        e = exp_read(a);
        @(negedge clk);
        cv = 1'b0;
        chk($sformatf("%s addr=%0d", tag, a), {16'h0, rd}, {16'h0, e});
    endtask

    task automatic rd_all(input string tag);
        for (int a = 0; a < 16; a++) rd_chk(a, tag);
    endtask

    task automatic pulse(input int bitn, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); trig[bitn] = 1'b1;
            @(negedge clk); trig[bitn] = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240517));
        trig = 8'h0F;                  // high levels held through reset
        repeat (4) @(negedge clk);
        chk("R1 rd_data after reset", {16'h0, rd}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk(0, "R2 level high at reset release not counted");
        trig = '0;
        rd_all("R1 bank empty after reset");

        // R2 held level counts once; R4 logic trigger edges.
        @(negedge clk); trig[3] = 1'b1;
        repeat (5) @(negedge clk); trig[3] = 1'b0;
        rd_chk(3, "R2 held level");
        chk("R2 held level literal", {16'h0, rd}, 32'd1);
        pulse(0, 3);
        rd_chk(0, "R2 three pulses");
        chk("R2 three pulses literal", {16'h0, rd}, 32'd3);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); ltrig = 1'b1;
            repeat (3) @(negedge clk); ltrig = 1'b0;
        end
        rd_chk(14, "R4 logic trigger edges");
        chk("R4 logic trigger literal", {16'h0, rd}, 32'd2);

        // R5 exact dead-time window.
        cmd(5'd11, 4'd12);
        lam = 1'b1;
        repeat (10) @(negedge clk);
        lam = 1'b0;
        rd_chk(12, "R5 ten clocks");
        chk("R5 ten clocks literal", {16'h0, rd}, 32'd10);

        // Random traffic, then R6 R7 R10 readback of every address.
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            trig  = N_TRIG'($urandom);
            ltrig = 1'($urandom);
            if ($urandom % 16 == 0) lam = ~lam;
        end
        trig = '0; ltrig = 1'b0; lam = 1'b0;
        rd_all("R6 R7 R10 random readback");
        @(negedge clk);
        chk("R6 rd_data holds without read", {16'h0, rd}, {16'h0, exp_read(15)});

        // R8 single clears.
        cmd(5'd11, 4'd2);
        cmd(5'd11, 4'd12);
        cmd(5'd11, 4'd14);
        rd_all("R8 single clears");
        // R8 clear wins over same-cycle edge, held level not recounted.
        @(negedge clk);
        cv = 1'b1; cf = 5'd11; ca = 4'd5; trig[5] = 1'b1;
        @(negedge clk); cv = 1'b0;
        repeat (3) @(negedge clk);
        trig[5] = 1'b0;
        rd_chk(5, "R8 clear beats edge");
        chk("R8 clear beats edge literal", {16'h0, rd}, 32'd0);

        // R10 ignored clears and foreign function.
        pulse(6, 4);
        cmd(5'd11, 4'd9);
        cmd(5'd11, 4'd13);
        cmd(5'd5, 4'd15);
        rd_all("R10 no effect");

        // R9 clear all.
        cmd(5'd11, 4'd15);
        rd_all("R9 clear all");

        // R3 event counter saturation.
        pulse(1, EMAX + 45);
        rd_chk(1, "R3 event saturation");
        chk("R3 event saturation literal", {16'h0, rd}, EMAX);

        // R3 R7 dead-time saturation and high half.
        lam = 1'b1;
        repeat (LMAX + 30) @(negedge clk);
        lam = 1'b0;
        rd_chk(12, "R3 dead time low half at full scale");
        chk("R3 dead time low literal", {16'h0, rd}, 32'hFFFF);
        rd_chk(13, "R7 dead time high half at full scale");
        chk("R7 dead time high literal", {16'h0, rd}, 32'h0001);

        finish_run();
    end
endmodule